// File: doc/BRIEF.md
# Pipelined Shift-Add Eight-Point Forward DCT

This block computes a one-dimensional eight-point forward discrete cosine transform on signed fixed-point samples. Eight samples enter in parallel and eight coefficients leave in parallel. The arithmetic uses only adders, subtractors and arithmetic right shifts. Each cosine weight is replaced by a short polynomial of shifted copies of its operand, so the datapath contains no multiplier.

The network has two register stages. The first stage folds the input into symmetric sums and antisymmetric differences. The second stage applies the shift-add weights and registers the coefficients. A new vector is taken on every clock, and a valid flag travels alongside the data. The coefficients are unnormalised: row 0 is weighted by c4 and the per-row scale factor is left to the caller. A full 2-D transform needs two passes through this block, with a transpose between them.

Top module: `dct8_pipe`

## Requirements
- R1: out_valid equals in_valid as it was two clock edges earlier. The coefficients for an input vector appear on out_vec in that same cycle.
- R2: While rst is high (synchronous, active high), every pipeline register is cleared. On the edge after rst is sampled high, out_valid is 0 and out_vec is all zeros. This holds even when vectors were in flight.
- R3: With lane n of in_vec at bits [32n+31:32n] as u(n), the block forms s(n)=u(n)+u(7-n) for n=0..3, then a=s(0)+s(3), b=s(1)+s(2), p=s(0)-s(3) and q=s(1)-s(2). The even outputs are y0=W4(a+b), y4=W4(a-b), y2=W2(p)+W6(q) and y6=W6(p)-W2(q). Coefficient k sits at out_vec bits [32k+31:32k]. An input with u(n)=-u(7-n) gives zero on all four even outputs.
- R4: With d(n)=u(n)-u(7-n), the odd outputs are:
  - y1=W1 d0+W3 d1+W5 d2+W7 d3
  - y3=W3 d0-W7 d1-W1 d2-W5 d3
  - y5=W5 d0-W1 d1+W7 d2+W3 d3
  - y7=W7 d0-W5 d1+W3 d2-W1 d3

  An input with u(n)=u(7-n) gives zero on all four odd outputs.
- R5: The weights are as follows, where >> is an arithmetic right shift:
  - W1(x)=x-(x>>6)-(x>>8)
  - W2(x)=x-(x>>4)-(x>>6)+(x>>9)
  - W3(x)=(x>>1)+(x>>2)+(x>>4)+(x>>6)+(x>>8)
  - W4(x)=t-(t>>6), with t=x-(x>>2)-(x>>5)
  - W5(x)=(x>>1)+(x>>4)-(x>>7)
  - W6(x)=(x>>2)+(x>>3)+(x>>7)
  - W7(x)=(x>>3)+(x>>4)+(x>>7)
- R6: All shifts keep the sign, and all sums wrap modulo 2^32. Negative samples produce the same coefficients as the 32-bit two's-complement evaluation of R3 to R5.
- R7: A new vector is accepted on every clock with in_valid high. Back-to-back vectors each produce their own coefficients two cycles later, with no stall and no mixing between vectors.
- R8: An input with all eight samples equal produces zero on outputs 1 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_vec as a vector to transform |
| in_vec | input | 256 | Eight signed 32-bit samples, lane n at bits [32n+31:32n] |
| out_valid | output | 1 | Marks out_vec as holding coefficients |
| out_vec | output | 256 | Eight signed 32-bit coefficients, lane k at bits [32k+31:32k] |

## Verification
Two events can land in the same cycle: a vector retiring from the output stage while the next one enters the butterfly stage, and a reset arriving while both stages hold valid data. The first is provoked with an unbroken stream of random vectors, interleaved with gaps. Every retiring vector is compared bit-exactly against an arithmetic model indexed by its cosine angle. The second is provoked by raising rst with two vectors in flight. The bench then expects out_valid low and all coefficients zero on the next sample, and expects no stale vector to appear after release.

// File: rtl/dct8_pkg.sv
package dct8_pkg;
    localparam int DATA_W   = 32;
    localparam int N_PTS    = 8;
    localparam int HALF_PTS = N_PTS / 2;
endpackage

// File: rtl/dct8_cmul.sv
// Constant weight by shift-add polynomial; K selects the cosine index.
module dct8_cmul #(
    parameter int W = dct8_pkg::DATA_W,
    parameter int K = 1
) (
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] p
);
    generate
        case (K)
            1: begin : g_w1
                assign p = x - (x >>> 6) - (x >>> 8);
            end
            2: begin : g_w2
                assign p = x - (x >>> 4) - (x >>> 6) + (x >>> 9);
            end
            3: begin : g_w3
                assign p = (x >>> 1) + (x >>> 2) + (x >>> 4) + (x >>> 6) + (x >>> 8);
            end
            4: begin : g_w4
                logic signed [W-1:0] t;
                assign t = x - (x >>> 2) - (x >>> 5);
                assign p = t - (t >>> 6);
            end
            5: begin : g_w5
                assign p = (x >>> 1) + (x >>> 4) - (x >>> 7);
            end
            6: begin : g_w6
                assign p = (x >>> 2) + (x >>> 3) + (x >>> 7);
            end
            default: begin : g_w7
                assign p = (x >>> 3) + (x >>> 4) + (x >>> 7);
            end
        endcase
    endgenerate
endmodule

// File: rtl/dct8_front.sv
// Input folding: symmetric sums reduced to the even-part operands, plus differences.
module dct8_front #(
    parameter int W = dct8_pkg::DATA_W
) (
    input  logic [dct8_pkg::N_PTS-1:0][W-1:0]    smp,
    output logic [dct8_pkg::HALF_PTS-1:0][W-1:0] ev_op,
    output logic [dct8_pkg::HALF_PTS-1:0][W-1:0] od_op
);
    localparam int N    = dct8_pkg::N_PTS;
    localparam int HALF = dct8_pkg::HALF_PTS;

    logic [HALF-1:0][W-1:0] sum_w;

    for (genvar n = 0; n < HALF; n++) begin : g_bfly
        assign sum_w[n] = smp[n] + smp[N-1-n];
        assign od_op[n] = smp[n] - smp[N-1-n];
    end

    assign ev_op[0] = sum_w[0] + sum_w[3];
    assign ev_op[1] = sum_w[1] + sum_w[2];
    assign ev_op[2] = sum_w[0] - sum_w[3];
    assign ev_op[3] = sum_w[1] - sum_w[2];
endmodule

// File: rtl/dct8_even.sv
// Even coefficients y0, y2, y4, y6 (result index k holds y(2k)).
module dct8_even #(
    parameter int W = dct8_pkg::DATA_W
) (
    input  logic [dct8_pkg::HALF_PTS-1:0][W-1:0] ev_op,
    output logic [dct8_pkg::HALF_PTS-1:0][W-1:0] ev_y
);
    logic signed [W-1:0] dc_in, nyq_in;
    logic signed [W-1:0] dc_p, nyq_p, p2_p, q6_p, p6_p, q2_p;

    assign dc_in  = $signed(ev_op[0] + ev_op[1]);
    assign nyq_in = $signed(ev_op[0] - ev_op[1]);

    dct8_cmul #(.W(W), .K(4)) u_dc  (.x(dc_in),             .p(dc_p));
    dct8_cmul #(.W(W), .K(4)) u_nyq (.x(nyq_in),            .p(nyq_p));
    dct8_cmul #(.W(W), .K(2)) u_p2  (.x($signed(ev_op[2])), .p(p2_p));
    dct8_cmul #(.W(W), .K(6)) u_q6  (.x($signed(ev_op[3])), .p(q6_p));
    dct8_cmul #(.W(W), .K(6)) u_p6  (.x($signed(ev_op[2])), .p(p6_p));
    dct8_cmul #(.W(W), .K(2)) u_q2  (.x($signed(ev_op[3])), .p(q2_p));

    assign ev_y[0] = dc_p;
    assign ev_y[1] = p2_p + q6_p;
    assign ev_y[2] = nyq_p;
    assign ev_y[3] = p6_p - q2_p;
endmodule

// File: rtl/dct8_odd.sv
// Odd coefficients y1, y3, y5, y7 (result index k holds y(2k+1)).
module dct8_odd #(
    parameter int W = dct8_pkg::DATA_W
) (
    input  logic [dct8_pkg::HALF_PTS-1:0][W-1:0] od_op,
    output logic [dct8_pkg::HALF_PTS-1:0][W-1:0] od_y
);
    localparam int HALF = dct8_pkg::HALF_PTS;

    // prd[c][j] = weight c(2c+1) applied to difference j
    logic [HALF-1:0][HALF-1:0][W-1:0] prd;

    for (genvar c = 0; c < HALF; c++) begin : g_wt
        for (genvar j = 0; j < HALF; j++) begin : g_col
            logic signed [W-1:0] pw;
            dct8_cmul #(.W(W), .K(2*c+1)) u_m (.x($signed(od_op[j])), .p(pw));
            assign prd[c][j] = pw;
        end
    end

    assign od_y[0] = prd[0][0] + prd[1][1] + prd[2][2] + prd[3][3];
    assign od_y[1] = prd[1][0] - prd[3][1] - prd[0][2] - prd[2][3];
    assign od_y[2] = prd[2][0] - prd[0][1] + prd[3][2] + prd[1][3];
    assign od_y[3] = prd[3][0] - prd[2][1] + prd[1][2] - prd[0][3];
endmodule

// File: rtl/dct8_pipe.sv
module dct8_pipe #(
    parameter int W = dct8_pkg::DATA_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    input  logic [dct8_pkg::N_PTS*W-1:0]   in_vec,
    output logic                           out_valid,
    output logic [dct8_pkg::N_PTS*W-1:0]   out_vec
);
    localparam int N    = dct8_pkg::N_PTS;
    localparam int HALF = dct8_pkg::HALF_PTS;

    typedef struct packed {
        logic                   vld;
        logic [HALF-1:0][W-1:0] ev;
        logic [HALF-1:0][W-1:0] od;
    } fold_st_t;

    typedef struct packed {
        logic                vld;
        logic [N-1:0][W-1:0] y;
    } coef_st_t;

    typedef struct packed {
        fold_st_t fold;
        coef_st_t coef;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [N-1:0][W-1:0]    smp;
    logic [HALF-1:0][W-1:0] ev_op_w, od_op_w;
    logic [HALF-1:0][W-1:0] ev_y_w, od_y_w;

    assign smp = in_vec;

    dct8_front #(.W(W)) u_front (
        .smp   (smp),
        .ev_op (ev_op_w),
        .od_op (od_op_w)
    );

    dct8_even #(.W(W)) u_even (
        .ev_op (pipe_q.fold.ev),
        .ev_y  (ev_y_w)
    );

    dct8_odd #(.W(W)) u_odd (
        .od_op (pipe_q.fold.od),
        .od_y  (od_y_w)
    );

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.fold.vld = in_valid;
        pipe_d.fold.ev  = ev_op_w;
        pipe_d.fold.od  = od_op_w;
        pipe_d.coef.vld = pipe_q.fold.vld;
        for (int k = 0; k < HALF; k++) begin
            pipe_d.coef.y[2*k]   = ev_y_w[k];
            pipe_d.coef.y[2*k+1] = od_y_w[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.coef.vld;
    assign out_vec   = pipe_q.coef.y;
endmodule

// File: rtl/dct8_pipe_chk.sv
module dct8_pipe_chk #(
    parameter int W = dct8_pkg::DATA_W
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_valid,
    input logic [dct8_pkg::N_PTS*W-1:0] in_vec,
    input logic                         out_valid,
    input logic [dct8_pkg::N_PTS*W-1:0] out_vec
);
    localparam int N = dct8_pkg::N_PTS;

    logic [N-1:0][W-1:0] iu, ov;
    logic [1:0]          age;
    logic                sym_in, asym_in, flat_in;

    assign iu = in_vec;
    assign ov = out_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= 2'd0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    always_comb begin
        sym_in  = 1'b1;
        asym_in = 1'b1;
        flat_in = 1'b1;
        for (int n = 0; n < N/2; n++) begin
            if (iu[n] != iu[N-1-n]) sym_in = 1'b0;
            if (W'(iu[n] + iu[N-1-n]) != '0) asym_in = 1'b0;
        end
        for (int n = 1; n < N; n++) begin
            if (iu[n] != iu[0]) flat_in = 1'b0;
        end
    end

    // R1
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_vec == '0));

    // R3
    even_null_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(asym_in, 2)) |->
        (ov[0] == '0 && ov[2] == '0 && ov[4] == '0 && ov[6] == '0));

    // R4
    odd_null_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(sym_in, 2)) |->
        (ov[1] == '0 && ov[3] == '0 && ov[5] == '0 && ov[7] == '0));

    // R8
    flat_ac_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(flat_in, 2)) |->
        (ov[1] == '0 && ov[2] == '0 && ov[3] == '0 && ov[4] == '0 &&
         ov[5] == '0 && ov[6] == '0 && ov[7] == '0));
endmodule

bind dct8_pipe dct8_pipe_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/dct8_pipe_tb.sv
module dct8_pipe_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [255:0] in_vec = '0;
    logic         out_valid;
    logic [255:0] out_vec;

    int n_chk  = 0;
    int n_fail = 0;

    logic [255:0] h1 = '0, h2 = '0;
    logic         h1v = 1'b0, h2v = 1'b0;
    string        h1t = "", h2t = "";
    int           hcnt = 0;

    always #5 clk = ~clk;

    dct8_pipe u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_vec    (in_vec),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

    // weight for cosine index c (R5)
    function automatic logic signed [31:0] wt(input int c, input logic signed [31:0] x);
        logic signed [31:0] t;
        case (c)
            1: return x - (x >>> 6) - (x >>> 8);
            2: return x - (x >>> 4) - (x >>> 6) + (x >>> 9);
            3: return (x >>> 1) + (x >>> 2) + (x >>> 4) + (x >>> 6) + (x >>> 8);
            4: begin t = x - (x >>> 2) - (x >>> 5); return t - (t >>> 6); end
            5: return (x >>> 1) + (x >>> 4) - (x >>> 7);
            6: return (x >>> 2) + (x >>> 3) + (x >>> 7);
            default: return (x >>> 3) + (x >>> 4) + (x >>> 7);
        endcase
    endfunction

    function automatic logic [255:0] model(input logic [255:0] v);
        logic signed [31:0] u [8];
        logic signed [31:0] s [4];
        logic signed [31:0] d [4];
        logic signed [31:0] y [8];
        logic signed [31:0] a, b, p, q, acc;
        logic [255:0] r;
        for (int n = 0; n < 8; n++) u[n] = v[32*n +: 32];
        for (int n = 0; n < 4; n++) begin
            s[n] = u[n] + u[7-n];
            d[n] = u[n] - u[7-n];
        end
        a = s[0] + s[3]; b = s[1] + s[2]; p = s[0] - s[3]; q = s[1] - s[2];
        y[0] = wt(4, a + b);
        y[4] = wt(4, a - b);
        y[2] = wt(2, p) + wt(6, q);
        y[6] = wt(6, p) - wt(2, q);
        // odd rows from the cosine angle (2n+1)k * pi/16
        for (int k = 1; k < 8; k += 2) begin
            acc = 0;
            for (int n = 0; n < 4; n++) begin
                int ang, ci;
                bit neg;
                ang = ((2*n+1)*k) % 32;
                if (ang > 16) ang = 32 - ang;
                neg = (ang > 8);
                ci  = neg ? 16 - ang : ang;
                if (neg) acc = acc - wt(ci, d[n]);
                else     acc = acc + wt(ci, d[n]);
            end
            y[k] = acc;
        end
        for (int k = 0; k < 8; k++) r[32*k +: 32] = y[k];
        return r;
    endfunction

    function automatic logic [255:0] fill(input logic signed [31:0] val);
        logic [255:0] r;
        for (int n = 0; n < 8; n++) r[32*n +: 32] = val;
        return r;
    endfunction

    task automatic step(input logic [255:0] v, input logic vl, input string tg);
        logic [255:0] exp_v;
        @(negedge clk);
        if (hcnt >= 2) begin
            n_chk++;
            if (out_valid !== h2v) begin
                n_fail++;
                $display("FAIL R1 out_valid act=%0b exp=%0b", out_valid, h2v);
            end
            if (h2v) begin
                n_chk++;
                exp_v = model(h2);
                for (int k = 0; k < 8; k++) begin
                    if (out_vec[32*k +: 32] !== exp_v[32*k +: 32]) begin
                        n_fail++;
                        $display("FAIL %s (%s) lane %0d act=%0d exp=%0d", tg == "" ? h2t : h2t,
                                 (k % 2 == 0) ? "R3" : "R4", k,
                                 $signed(out_vec[32*k +: 32]), $signed(exp_v[32*k +: 32]));
                    end
                end
                if (h2t == "R8") begin
                    n_chk++;
                    for (int k = 1; k < 8; k++) begin
                        if (out_vec[32*k +: 32] !== 32'd0) begin
                            n_fail++;
                            $display("FAIL R8 lane %0d act=%0d exp=0", k, $signed(out_vec[32*k +: 32]));
                        end
                    end
                end
            end
        end
        h2 = h1; h2v = h1v; h2t = h1t;
        h1 = v;  h1v = vl;  h1t = tg;
        if (hcnt < 2) hcnt++;
        in_vec   = v;
        in_valid = vl;
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (cycles) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            n_fail++;
            $display("FAIL R2 after reset act valid=%0b vec=%h exp valid=0 vec=0", out_valid, out_vec);
        end
        rst  = 1'b0;
        hcnt = 0;
        h1v  = 1'b0; h2v = 1'b0;
    endtask

    function automatic logic [255:0] rnd_vec(input int sh);
        logic [255:0] r;
        for (int n = 0; n < 8; n++) r[32*n +: 32] = $signed($urandom) >>> sh;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [255:0] v;
        // R2: reset state
        do_reset(3);

        // R5: impulse in every lane, positive and negative (R6)
        for (int n = 0; n < 8; n++) begin
            v = '0; v[32*n +: 32] = 32'sd1 <<< 20;
            step(v, 1'b1, "R5");
            v = '0; v[32*n +: 32] = -(32'sd1 <<< 18) - 32'sd77;
            step(v, 1'b1, "R6");
        end

        // R8: flat inputs, including negative and odd values
        step(fill(32'sd1000), 1'b1, "R8");
        step(fill(-32'sd123457), 1'b1, "R8");
        step(fill(32'sd1), 1'b1, "R8");

        // R4: symmetric input; R3: antisymmetric input
        for (int i = 0; i < 6; i++) begin
            v = rnd_vec(8);
            for (int n = 0; n < 4; n++) v[32*(7-n) +: 32] = v[32*n +: 32];
            step(v, 1'b1, "R4");
            for (int n = 0; n < 4; n++) v[32*(7-n) +: 32] = -$signed(v[32*n +: 32]);
            step(v, 1'b1, "R3");
        end

        // R6: full-range values exercise wraparound
        for (int i = 0; i < 16; i++) step(rnd_vec(0), 1'b1, "R6");

        // R7: back-to-back stream
        for (int i = 0; i < 200; i++) step(rnd_vec(6), 1'b1, "R7");

        // R1: gaps in the stream
        for (int i = 0; i < 200; i++) step(rnd_vec(6), ($urandom % 3) != 0, "R1");

        // R2: reset with both stages holding valid vectors
        step(rnd_vec(4), 1'b1, "R2");
        step(rnd_vec(4), 1'b1, "R2");
        do_reset(1);
        for (int i = 0; i < 4; i++) step(rnd_vec(4), 1'b0, "R2");
        step(fill(32'sd42), 1'b1, "R8");
        step('0, 1'b0, "R1");
        step('0, 1'b0, "R1");
        step('0, 1'b0, "R1");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule